// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is a watchdog counter that runs on its own clock. A prescaler with eight power-of-two division ratios divides that clock and drives a fixed-width main counter. If software does not restart the counter before it wraps, the block emits a one-cycle `timeout` pulse. Software restarts the counter in one of two ways, chosen by a configuration option. In the first, a single clear strobe is enough. In the second, two separate clear strobes must both arrive, in either order and at any spacing, before the restart takes effect.

The watchdog is turned off only when the configuration enable is low and the 4-bit enable key holds the one disabling pattern. Entering the low-power halt state restarts the counter and sets `in_halt`. `in_halt` stays high through the cycle of a timeout pulse, so the consumer can tell a warm wake-up (only the program counter and stack pointer are reset) from a full chip reset.

Top module: `wdg_timer`

## Requirements
- R1: While `rst_n` is low, `timeout` and `in_halt` are 0. The first `timeout` is high in the cycle after the 2^(CNT_W+div_sel)-th rising edge that follows reset release.
- R2: With `div_sel` = n, the prescaler divides by 2^n, so a restart is followed by `timeout` exactly 2^(CNT_W+n) edges later.
- R3: `timeout` is high for exactly one cycle. The counter then restarts from zero, and the next pulse comes a full period after the pulse edge.
- R4: With `pair_mode` = 0, a `clr_single` strobe restarts the counter and the prescaler at its edge. `clr_one` and `clr_two` have no effect.
- R5: With `pair_mode` = 1, the restart happens at the edge where the second of `clr_one` and `clr_two` has been seen. The two may arrive in either order or in the same cycle. Both remembered flags then drop, and `clr_single` has no effect.
- R6: With `pair_mode` = 1, a lone `clr_one` (or `clr_two`) leaves the timeout on its original schedule.
- R7: The counter is frozen, and no timeout occurs, only when `en_opt` = 0 and `en_key` = 4'b1010. Any other key value (for example 4'b0101 or 4'b1011), or `en_opt` = 1, lets the counter run.
- R8: A `halt` strobe restarts the counter and prescaler, drops both remembered pair flags, and sets `in_halt` from the next cycle on.
- R9: A timeout while `in_halt` = 1 (warm wake-up) shows `in_halt` = 1 during the pulse and 0 the cycle after. A timeout with `in_halt` = 0 denotes a full reset.
- R10: Driving `rst_n` low clears `in_halt`, `timeout`, the counters and the pair flags at once, without waiting for a clock edge.
- R11: A restart at the same edge where the counter would wrap wins: no pulse appears, and the next pulse comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| clr_single | input | 1 | One-cycle strobe of the single clear instruction |
| clr_one | input | 1 | One-cycle strobe of the first paired clear instruction |
| clr_two | input | 1 | One-cycle strobe of the second paired clear instruction |
| halt | input | 1 | One-cycle strobe marking entry to halt |
| en_key | input | 4 | Enable key; 4'b1010 disables, 4'b0101 is the preferred enable value |
| en_opt | input | 1 | Configuration enable; 1 forces the watchdog on |
| pair_mode | input | 1 | Clear mode option: 0 single strobe, 1 paired strobes |
| div_sel | input | SEL_W | Prescaler select; value n divides by 2^n |
| timeout | output | 1 | One-cycle overflow pulse |
| in_halt | output | 1 | High while the chip is halted; qualifies `timeout` as a warm wake-up |

## Verification
Every restart (clear, halt, reset release or a previous pulse) starts a period of 2^(CNT_W+div_sel) rising edges. `timeout` goes high just after the last edge of that period, one register stage after the wrapping edge. `in_halt` rises one edge after a `halt` strobe and falls one edge after a warm-wake pulse. The bench drives strobes and samples outputs on falling edges, and counts rising edges from the restart edge, so each expected value is compared in the exact cycle where it is due. The asynchronous reset is checked a fraction of a cycle after `rst_n` falls, with no clock edge in between.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  // The single key value that turns the watchdog off (when the option also does)
  localparam logic [3:0] WDG_KEY_OFF = 4'b1010;

  typedef enum logic {
    CLR_MODE_SINGLE = 1'b0,
    CLR_MODE_PAIR   = 1'b1
  } clr_mode_e;

  // Watchdog runs when either source enables it
  function automatic logic wdg_is_enabled(input logic cfg_on, input logic [3:0] key);
    return cfg_on | (key != WDG_KEY_OFF);
  endfunction

  // Pair completes once each half is either remembered or striking now
  function automatic logic wdg_pair_complete(input logic seen_a, input logic hit_a,
                                             input logic seen_b, input logic hit_b);
    return (seen_a | hit_a) & (seen_b | hit_b);
  endfunction

  // Prescaler terminal test: the low 'sel' bits are all ones
  function automatic logic wdg_low_bits_full(input logic bit_val, input int bit_idx,
                                             input int sel);
    return bit_val | (bit_idx >= sel);
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
`timescale 1ns/1ps
module wdg_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import wdg_pkg::*;

  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_full;

  // One terminal-test bit per prescaler stage; stages at or above sel are don't-care
  generate
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_term
      assign low_full[gi] = wdg_low_bits_full(pre_q[gi], gi, int'(sel));
    end
  endgenerate

  assign tick = run & (&low_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_main_counter.sv
`timescale 1ns/1ps
module wdg_main_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      // a restart in the wrap cycle suppresses the pulse
      wrap_pulse <= step & ~clear & (count == CNT_TOP);
      if (clear) begin
        count <= '0;
      end else if (step) begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdg_clear_ctrl.sv
`timescale 1ns/1ps
module wdg_clear_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_mode,
  input  logic clr_single,
  input  logic clr_one,
  input  logic clr_two,
  input  logic halt,
  output logic sw_clear,
  output logic seen_one,
  output logic seen_two
);
  import wdg_pkg::*;

  clr_mode_e mode;
  logic      pair_done;

  assign mode      = clr_mode_e'(pair_mode);
  assign pair_done = wdg_pair_complete(seen_one, clr_one, seen_two, clr_two);

  always_comb begin
    if (mode == CLR_MODE_PAIR) sw_clear = pair_done;
    else                       sw_clear = clr_single;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_one <= 1'b0;
      seen_two <= 1'b0;
    end else if (mode != CLR_MODE_PAIR || halt || pair_done) begin
      seen_one <= 1'b0;
      seen_two <= 1'b0;
    end else begin
      seen_one <= seen_one | clr_one;
      seen_two <= seen_two | clr_two;
    end
  end

endmodule

// File: rtl/wdg_timer.sv
`timescale 1ns/1ps
module wdg_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_single,
  input  logic             clr_one,
  input  logic             clr_two,
  input  logic             halt,
  input  logic [3:0]       en_key,
  input  logic             en_opt,
  input  logic             pair_mode,
  input  logic [SEL_W-1:0] div_sel,
  output logic             timeout,
  output logic             in_halt
);
  import wdg_pkg::*;

  // named internal events, visible to the bound checker
  logic             wdt_on;
  logic             sw_clear;
  logic             clear_evt;
  logic             pre_tick;
  logic             seen_one;
  logic             seen_two;
  logic [CNT_W-1:0] count_q;
  logic             in_halt_q;

  assign wdt_on    = wdg_is_enabled(en_opt, en_key);
  assign clear_evt = sw_clear | halt;

  wdg_clear_ctrl u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_mode  (pair_mode),
    .clr_single (clr_single),
    .clr_one    (clr_one),
    .clr_two    (clr_two),
    .halt       (halt),
    .sw_clear   (sw_clear),
    .seen_one   (seen_one),
    .seen_two   (seen_two)
  );

  wdg_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_evt),
    .run   (wdt_on),
    .sel   (div_sel),
    .tick  (pre_tick)
  );

  wdg_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear_evt),
    .step       (pre_tick),
    .count      (count_q),
    .wrap_pulse (timeout)
  );

  // halt state: entered by strobe, left on the wake pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_halt_q <= 1'b0;
    else if (halt)    in_halt_q <= 1'b1;
    else if (timeout) in_halt_q <= 1'b0;
  end

  assign in_halt = in_halt_q;

endmodule

// File: rtl/wdg_checker.sv
`timescale 1ns/1ps
module wdg_checker #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_single,
  input logic             clr_two,
  input logic             halt,
  input logic [3:0]       en_key,
  input logic             en_opt,
  input logic             pair_mode,
  input logic             timeout,
  input logic             in_halt,
  input logic             sw_clear,
  input logic             clear_evt,
  input logic             pre_tick,
  input logic             seen_two,
  input logic [CNT_W-1:0] count
);

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && !clear_evt) |=> count == CNT_W'($past(count) + 1'b1));

  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  a_r4_single_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_mode && clr_single) |-> sw_clear);

  a_r5_pair_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && !clr_two && !seen_two) |-> !sw_clear);

  a_r7_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_opt && en_key == 4'b1010 && !clear_evt) |=> $stable(count));

  a_r8_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> in_halt);

  a_r9_wake_leaves_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !halt) |=> !in_halt);

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !timeout);

endmodule

bind wdg_timer wdg_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_wdg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_single (clr_single),
  .clr_two    (clr_two),
  .halt       (halt),
  .en_key     (en_key),
  .en_opt     (en_opt),
  .pair_mode  (pair_mode),
  .timeout    (timeout),
  .in_halt    (in_halt),
  .sw_clear   (sw_clear),
  .clear_evt  (clear_evt),
  .pre_tick   (pre_tick),
  .seen_two   (seen_two),
  .count      (count_q)
);

// File: tb/tb_wdg_timer.sv
`timescale 1ns/1ps
module tb_wdg_timer;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  localparam int S_SINGLE = 0;
  localparam int S_ONE    = 1;
  localparam int S_TWO    = 2;
  localparam int S_BOTH   = 3;
  localparam int S_HALT   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr_single = 1'b0, clr_one = 1'b0, clr_two = 1'b0, halt = 1'b0;
  logic [3:0]       en_key = 4'b0101;
  logic             en_opt = 1'b0;
  logic             pair_mode = 1'b0;
  logic [SEL_W-1:0] div_sel = '0;
  logic             timeout, in_halt;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  wdg_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_single(clr_single), .clr_one(clr_one),
    .clr_two(clr_two), .halt(halt), .en_key(en_key), .en_opt(en_opt),
    .pair_mode(pair_mode), .div_sel(div_sel), .timeout(timeout), .in_halt(in_halt)
  );

  function automatic int period(input int sel);
    return 1 << (CNT_W + sel);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // n rising edges during which no pulse may appear
  task automatic run_quiet(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (timeout) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  // one-edge strobe, driven and released on falling edges
  task automatic strobe(input int which);
    case (which)
      S_SINGLE: clr_single = 1'b1;
      S_ONE:    clr_one = 1'b1;
      S_TWO:    clr_two = 1'b1;
      S_BOTH:   begin clr_one = 1'b1; clr_two = 1'b1; end
      default:  halt = 1'b1;
    endcase
    @(posedge clk); @(negedge clk);
    clr_single = 1'b0; clr_one = 1'b0; clr_two = 1'b0; halt = 1'b0;
  endtask

  // pulse due after 'remaining' edges; consumes one extra edge to see it end
  task automatic expect_to(input int remaining, input string tag, input bit exp_halt);
    int n = 0;
    bit hit = 1'b0;
    while (!hit && n < remaining + 8) begin
      @(posedge clk); n++; @(negedge clk);
      if (timeout) hit = 1'b1;
    end
    check(hit && n == remaining, tag, n, remaining);
    if (hit) check(in_halt == exp_halt, "R9 halt flag at pulse", int'(in_halt), int'(exp_halt));
    @(posedge clk); @(negedge clk);
    check(!timeout, "R3 pulse width", int'(timeout), 0);
    if (exp_halt) check(!in_halt, "R9 halt flag after wake", int'(in_halt), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!timeout, "R10 timeout in reset", int'(timeout), 0);
    check(!in_halt, "R1 halt flag in reset", int'(in_halt), 0);
    rst_n = 1'b1;
    expect_to(period(0), "R1 first period", 1'b0);
  endtask

  task automatic t_periods();
    int sels[3] = '{1, 3, 7};
    foreach (sels[i]) begin
      div_sel = SEL_W'(sels[i]);
      strobe(S_SINGLE);
      expect_to(period(sels[i]), "R2 period", 1'b0);
      expect_to(period(sels[i]) - 1, "R3 back-to-back", 1'b0);
    end
    div_sel = '0;
  endtask

  task automatic t_single();
    strobe(S_SINGLE);
    run_quiet(100, "R4 before restart");
    strobe(S_SINGLE);
    expect_to(period(0), "R4 single restart", 1'b0);
    strobe(S_ONE);
    run_quiet(40, "R4 quiet");
    strobe(S_TWO);
    expect_to(period(0) - 43, "R4 pair strobes ignored", 1'b0);
  endtask

  task automatic t_pair();
    pair_mode = 1'b1;
    strobe(S_BOTH);
    expect_to(period(0), "R5 same-cycle pair", 1'b0);
    run_quiet(50, "R5 quiet");
    strobe(S_TWO);
    run_quiet(50, "R5 quiet after two");
    strobe(S_ONE);
    expect_to(period(0), "R5 reversed pair", 1'b0);
    run_quiet(29, "R6 quiet");
    strobe(S_ONE);
    expect_to(period(0) - 31, "R6 lone half", 1'b0);
    strobe(S_SINGLE);
    expect_to(period(0) - 2, "R5 single ignored", 1'b0);
  endtask

  task automatic t_halt();
    // one half is still remembered from the previous scenario
    run_quiet(20, "R8 quiet");
    strobe(S_HALT);
    check(in_halt, "R8 halt flag set", int'(in_halt), 1);
    strobe(S_TWO);
    expect_to(period(0) - 1, "R8 halt restart and flag drop", 1'b1);
    pair_mode = 1'b0;
  endtask

  task automatic t_same_edge();
    strobe(S_SINGLE);
    run_quiet(period(0) - 1, "R11 quiet");
    strobe(S_SINGLE);
    check(!timeout, "R11 no pulse on restart edge", int'(timeout), 0);
    expect_to(period(0), "R11 full period", 1'b0);
  endtask

  task automatic t_enable();
    strobe(S_SINGLE);
    run_quiet(100, "R7 quiet");
    en_key = 4'b1010;
    run_quiet(3 * period(0), "R7 disabled");
    en_key = 4'b1011;
    expect_to(period(0) - 100, "R7 frozen then resumed", 1'b0);
    en_opt = 1'b1;
    en_key = 4'b1010;
    expect_to(period(0) - 1, "R7 option forces on", 1'b0);
    en_opt = 1'b0;
    en_key = 4'b0101;
  endtask

  task automatic t_async();
    strobe(S_HALT);
    run_quiet(10, "R10 quiet");
    #1 rst_n = 1'b0;
    #0.5;
    check(!in_halt, "R10 async halt flag", int'(in_halt), 0);
    check(!timeout, "R10 async pulse", int'(timeout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_to(period(0), "R10 period after reset", 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 180000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_periods();
    t_single();
    t_pair();
    t_halt();
    t_same_edge();
    t_enable();
    t_async();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule